// File: doc/BRIEF.md
# Double-Buffered PWM/PPG Timer

This block is an 8-bit up-counting timer with two compare registers and three operating modes: an interval timer, a pulse-width modulator with a selectable power-of-two period, and a programmable pulse generator whose period is set by the second compare register. The counter advances by one on each clock where the prescale tick is high and the run control is set. When the run control drops, the counter and the waveform return to zero. The compare registers keep their values.

The first compare register has a shadow copy, and both sit at one write address. With buffering off, a write goes to both the shadow and the live compare value. With buffering on, a write goes to the shadow only. The shadow is then copied into the live register at the point where a new waveform period begins. This lets software change a duty value without producing a broken pulse. Interval mode has no period start, so a buffered write does not reach the live register in that mode.

Top module: `pwm_ppg_timer`

## Requirements
- R1: After reset, match_o and wave_o are 0, buffering is off and both compare registers hold 0.
- R2: A write to address 0 with buffering off sets both the shadow and the live first compare value. Address 1 sets the second compare value. Address 2 bit 0 sets the buffer enable.
- R3: A write to address 0 with buffering on changes only the shadow. In interval mode (mode_i 0 or 3) the live value is never taken from the shadow.
- R4: The counter steps only when tick_i and run_i are both high. With run_i low, the counter and wave_o clear on the next clock and match_o stays low. Register contents are unaffected.
- R5: match_o is a one-clock pulse in the clock after a tick on which the counter equals the live first compare value.
- R6: With a live first compare value of 0, the match happens on the counter's last count instead: 255, or the PWM period end in mode 1.
- R7: In interval mode, a match returns the counter to 0 and toggles wave_o.
- R8: In PWM mode (mode_i 1), the counter runs modulo 64, 128 or 256 for pwm_len_i 1, 2, or 0/3. wave_o is set at the wrap tick and cleared on a match; when both happen on the same tick, the set wins.
- R9: In PWM mode with buffering on, the shadow is copied to the live register on the wrap tick.
- R10: In PPG mode (mode_i 2), a tick on which the counter equals the second compare value starts a new cycle; a second compare value of 0 means 255. The counter then returns to 0 and wave_o is set, and a first-compare match toggles wave_o. A cycle start wins over a simultaneous toggle.
- R11: In PPG mode with buffering on, the shadow is copied to the live register at each cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low clears the counter |
| tick_i | input | 1 | Prescale count enable |
| mode_i | input | 2 | 0 interval, 1 PWM, 2 PPG, 3 interval |
| pwm_len_i | input | 2 | PWM period select |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| match_o | output | 1 | First-compare match pulse |
| wave_o | output | 1 | Timer waveform output |

## Verification
The assertions assume that mode_i and pwm_len_i are held steady while the timer runs, and that the write port issues at most one write per clock. The stimulus changes mode and period only with the timer stopped, or at a point where the reference model tracks the change cycle by cycle. Tick patterns include continuous, periodic and random ticks, so that match, wrap and shadow transfer events are reached on both dense and sparse steps.

// File: rtl/pwm_ppg_pkg.sv
package pwm_ppg_pkg;
  typedef enum logic [1:0] {
    MODE_IVL = 2'd0,
    MODE_PWM = 2'd1,
    MODE_PPG = 2'd2,
    MODE_RSV = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADR_CMP0 = 2'd0;
  localparam logic [1:0] ADR_CMP1 = 2'd1;
  localparam logic [1:0] ADR_CTL  = 2'd2;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          xfer_i,
  output logic [W-1:0]  cmp0_o,
  output logic [W-1:0]  cmp1_o,
  output logic [W-1:0]  shadow_o,
  output logic          buf_en_o
);
  import pwm_ppg_pkg::*;

  logic wr_cmp0, wr_cmp1, wr_ctl;

  assign wr_cmp0 = wr_en_i && (wr_addr_i == AW'(ADR_CMP0));
  assign wr_cmp1 = wr_en_i && (wr_addr_i == AW'(ADR_CMP1));
  assign wr_ctl  = wr_en_i && (wr_addr_i == AW'(ADR_CTL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      cmp0_o   <= '0;
      cmp1_o   <= '0;
      buf_en_o <= 1'b0;
    end else begin
      if (wr_cmp0) shadow_o <= wr_data_i;
      // direct path only when buffering is off; transfer only when on
      if (wr_cmp0 && !buf_en_o) cmp0_o <= wr_data_i;
      else if (xfer_i)          cmp0_o <= shadow_o;
      if (wr_cmp1) cmp1_o <= wr_data_i;
      if (wr_ctl)  buf_en_o <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   len_i,
  input  logic [W-1:0] cmp0_i,
  input  logic [W-1:0] cmp1_i,
  input  logic         buf_en_i,
  output logic [W-1:0] cnt_o,
  output logic         ev_match_o,
  output logic         ev_start_o,
  output logic         xfer_o
);
  import pwm_ppg_pkg::*;

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] mask, top, cnt_inc;
  logic         step, is_pwm, is_ppg, hit0, hit1, wrap;

  assign is_pwm = (mode_i == MODE_PWM);
  assign is_ppg = (mode_i == MODE_PPG);
  assign step   = run_i && tick_i;

  always_comb begin
    unique case (len_i)
      2'd1:    mask = CNT_MAX >> 2;
      2'd2:    mask = CNT_MAX >> 1;
      default: mask = CNT_MAX;
    endcase
  end

  assign top     = is_pwm ? mask : CNT_MAX;
  assign hit0    = (cmp0_i == '0) ? (cnt_o == top) : (cnt_o == cmp0_i);
  assign hit1    = (cmp1_i == '0) ? (cnt_o == CNT_MAX) : (cnt_o == cmp1_i);
  assign wrap    = (cnt_o == mask);
  assign cnt_inc = cnt_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (!run_i) begin
      cnt_o <= '0;
    end else if (step) begin
      if (is_pwm)      cnt_o <= cnt_inc & mask;
      else if (is_ppg) cnt_o <= hit1 ? '0 : cnt_inc;
      else             cnt_o <= hit0 ? '0 : cnt_inc;
    end
  end

  assign ev_match_o = step && hit0;
  assign ev_start_o = step && ((is_pwm && wrap) || (is_ppg && hit1));
  assign xfer_o     = ev_start_o && buf_en_i;
endmodule

// File: rtl/ppg_wave.sv
module ppg_wave (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] mode_i,
  input  logic       ev_match_i,
  input  logic       ev_start_i,
  output logic       match_o,
  output logic       wave_o
);
  import pwm_ppg_pkg::*;

  logic wave_d;

  always_comb begin
    wave_d = wave_o;
    unique case (mode_i)
      MODE_PWM: begin
        if (ev_start_i)      wave_d = 1'b1;
        else if (ev_match_i) wave_d = 1'b0;
      end
      MODE_PPG: begin
        if (ev_start_i)      wave_d = 1'b1;
        else if (ev_match_i) wave_d = ~wave_o;
      end
      default: begin
        if (ev_match_i) wave_d = ~wave_o;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      wave_o  <= 1'b0;
    end else if (!run_i) begin
      match_o <= 1'b0;
      wave_o  <= 1'b0;
    end else begin
      match_o <= ev_match_i;
      wave_o  <= wave_d;
    end
  end
endmodule

// File: rtl/pwm_ppg_timer.sv
module pwm_ppg_timer #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        pwm_len_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              match_o,
  output logic              wave_o
);
  logic [CNT_W-1:0] cmp0, cmp1, shadow, cnt;
  logic             buf_en, xfer, ev_match, ev_start;

  ppg_regs #(.W(CNT_W), .AW(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .xfer_i    (xfer),
    .cmp0_o    (cmp0),
    .cmp1_o    (cmp1),
    .shadow_o  (shadow),
    .buf_en_o  (buf_en)
  );

  ppg_counter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .len_i      (pwm_len_i),
    .cmp0_i     (cmp0),
    .cmp1_i     (cmp1),
    .buf_en_i   (buf_en),
    .cnt_o      (cnt),
    .ev_match_o (ev_match),
    .ev_start_o (ev_start),
    .xfer_o     (xfer)
  );

  ppg_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .mode_i     (mode_i),
    .ev_match_i (ev_match),
    .ev_start_i (ev_start),
    .match_o    (match_o),
    .wave_o     (wave_o)
  );
endmodule

// File: rtl/pwm_ppg_timer_chk.sv
module pwm_ppg_timer_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              match_o,
  input logic              wave_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp0,
  input logic [CNT_W-1:0]  shadow,
  input logic              buf_en,
  input logic              xfer
);
  a_r2_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0 && !buf_en) |=>
      (cmp0 == $past(wr_data_i) && shadow == $past(wr_data_i)));

  a_r3_shadow_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en && !xfer) |=> $stable(cmp0));

  a_r4_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt == '0 && !wave_o && !match_o));

  a_r5_match_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(run_i && tick_i));

  a_r9_xfer_loads_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> cmp0 == $past(shadow));
endmodule

bind pwm_ppg_timer pwm_ppg_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .match_o   (match_o),
  .wave_o    (wave_o),
  .cnt       (cnt),
  .cmp0      (cmp0),
  .shadow    (shadow),
  .buf_en    (buf_en),
  .xfer      (xfer)
);

// File: tb/pwm_ppg_timer_bench.sv
`timescale 1ns/1ps
module pwm_ppg_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [1:0] pwm_len_i = 2'd0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic       match_o, wave_o;

  pwm_ppg_timer u_pwm_ppg_timer (.*);

  always #2.5 clk_i = ~clk_i;

  int    n_checks = 0;
  int    n_fail = 0;
  int    tick_sel = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_cmp0, m_cmp1, m_sh, m_ben, m_match, m_wave;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0; m_sh = 0;
      m_ben = 0; m_match = 0; m_wave = 0;
    end else begin
      int  lim, per_end, new_cmp0;
      bit  h0, h1, st, step;
      lim      = (mode_i == 2'd1) ? ((pwm_len_i == 2'd1) ? 63 :
                                     (pwm_len_i == 2'd2) ? 127 : 255) : 255;
      per_end  = (m_cmp1 == 0) ? 255 : m_cmp1;
      h0       = (m_cmp0 == 0) ? (m_cnt == lim) : (m_cnt == m_cmp0);
      h1       = (m_cnt == per_end);
      step     = run_i && tick_i;
      st       = 0;
      new_cmp0 = m_cmp0;
      if (!run_i) begin
        m_cnt = 0; m_wave = 0; m_match = 0;
      end else begin
        m_match = step && h0;
        if (step) begin
          if (mode_i == 2'd1) begin
            st = (m_cnt == lim);
            m_cnt = (m_cnt + 1) % (lim + 1);
            if (st) m_wave = 1; else if (h0) m_wave = 0;
          end else if (mode_i == 2'd2) begin
            st = h1;
            m_cnt = h1 ? 0 : (m_cnt + 1) % 256;
            if (st) m_wave = 1; else if (h0) m_wave = 1 - m_wave;
          end else begin
            m_cnt = h0 ? 0 : (m_cnt + 1) % 256;
            if (h0) m_wave = 1 - m_wave;
          end
        end
      end
      if (st && m_ben == 1) new_cmp0 = m_sh;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin
            if (m_ben == 0) new_cmp0 = wr_data_i;
            m_sh = wr_data_i;
          end
          2'd1: m_cmp1 = wr_data_i;
          2'd2: m_ben = wr_data_i[0];
          default: ;
        endcase
      end
      m_cmp0 = new_cmp0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    cyc++;
    n_checks++;
    if (match_o !== m_match[0]) begin
      n_fail++;
      $display("FAIL %s match_o act=%0d exp=%0d cyc=%0d", cur_req, match_o, m_match, cyc);
    end
    n_checks++;
    if (wave_o !== m_wave[0]) begin
      n_fail++;
      $display("FAIL %s wave_o act=%0d exp=%0d cyc=%0d", cur_req, wave_o, m_wave, cyc);
    end
    case (tick_sel)
      0:       tick_i <= 1'b1;
      1:       tick_i <= 1'($urandom_range(0, 1));
      default: tick_i <= ((cyc % tick_sel) == 0);
    endcase
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i <= 1'b1; wr_addr_i <= a; wr_data_i <= d;
    @(negedge clk_i);
    wr_en_i <= 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    cycles(150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    cycles(4);
    rst_ni = 1'b1;
    cycles(2);
    // R6: zero compare -> match on overflow in interval mode
    cur_req = "R6"; run_i <= 1'b1; cycles(600);
    // R2 / R5 / R7: direct compare write, interval restart and toggle
    cur_req = "R2"; wr(2'd0, 8'd5); cycles(40);
    cur_req = "R7"; cycles(60);
    tick_sel = 3; cur_req = "R5"; cycles(200);
    tick_sel = 1; cycles(200);
    // R4: stop clears counter and wave, registers survive
    tick_sel = 0; cur_req = "R4"; run_i <= 1'b0; cycles(10);
    run_i <= 1'b1; cycles(50);
    // R3: buffered write has no effect in interval mode
    cur_req = "R3"; wr(2'd2, 8'd1); wr(2'd0, 8'd9); cycles(200);
    mode_i <= 2'd3; cycles(100);
    // R8: PWM periods
    cur_req = "R8"; run_i <= 1'b0; mode_i <= 2'd1; pwm_len_i <= 2'd1;
    wr(2'd2, 8'd0); wr(2'd0, 8'd20); run_i <= 1'b1; cycles(300);
    run_i <= 1'b0; pwm_len_i <= 2'd2; cycles(2); run_i <= 1'b1; cycles(300);
    run_i <= 1'b0; pwm_len_i <= 2'd0; wr(2'd0, 8'd200); run_i <= 1'b1; cycles(600);
    run_i <= 1'b0; pwm_len_i <= 2'd3; cycles(2); run_i <= 1'b1; tick_sel = 1; cycles(600);
    // R9: buffered PWM duty update at wrap
    tick_sel = 0; cur_req = "R9"; run_i <= 1'b0; pwm_len_i <= 2'd1; cycles(2);
    wr(2'd2, 8'd1); run_i <= 1'b1; cycles(30); wr(2'd0, 8'd45); cycles(300);
    cur_req = "R6"; wr(2'd0, 8'd0); cycles(200);
    // R10: PPG period and toggle
    cur_req = "R10"; run_i <= 1'b0; mode_i <= 2'd2; cycles(2);
    wr(2'd2, 8'd0); wr(2'd1, 8'd30); wr(2'd0, 8'd10); run_i <= 1'b1; cycles(300);
    wr(2'd1, 8'd0); cycles(600);
    // R11: buffered PPG update at cycle start
    cur_req = "R11"; wr(2'd1, 8'd40); wr(2'd2, 8'd1); cycles(17); wr(2'd0, 8'd25);
    cycles(300); tick_sel = 1; wr(2'd0, 8'd3); cycles(400);
    cur_req = "R4"; run_i <= 1'b0; cycles(10);
    finish_run();
  end
endmodule